// File: doc/BRIEF.md
# LVDS Lane Bit-Mux Serializer

This block turns a parallel pixel word into serial LVDS lane streams. Each pixel word is 28 bits wide. Bits 23:0 carry RGB data and bits 27:24 carry control bits (horizontal sync, vertical sync, data enable and one spare). The block runs on a single fast clock. A bit-clock enable `bit_en_i` marks each serial bit time, so every seven enabled cycles make up one pixel.

Every bit slot of every data lane is set by a 5-bit source index into the pixel word. A select table supplies these indices, so one datapath can carry either an 18-bit or a 24-bit lane plan. A depth code picks how many data lanes each channel drives. A channel count and a channel swap decide which physical channel carries which pixel word. Each channel also has a clock lane that repeats a fixed 7-bit pattern.

Serialization starts only after the interface has been enabled with a legal depth for a settling interval. It also needs the serialization enable.

Top module: `lvds_lane_serializer`

## Requirements
- R1: After reset, every data lane, every clock lane and `pix_load_o` are 0.
- R2: The block becomes active only when `intf_en_i` is 1 with a legal depth, that condition has held for SETTLE_CYC consecutive clocks, and `ser_en_i` is 1. Before that, `ser_en_i` and `bit_en_i` have no effect. Dropping `intf_en_i` or going to an illegal depth restarts the count.
- R3: The depth code `depth_i` selects the lanes. Code 2'b01 is 18-bit mode and drives lanes 0..2. Code 2'b10 is 24-bit mode and drives lanes 0..3. Codes 2'b00 and 2'b11 are rejected: the block stays inactive with all outputs 0.
- R4: While active, each cycle with `bit_en_i` high sends the next slot, in the order slot 6 down to slot 0, then repeats. Slot s of lane l takes its 5-bit source index from `sel_i[(l*7+s)*5 +: 5]`.
- R5: A source index of 0..27 selects that bit of the captured pixel word. An index of 28..31 sends 0.
- R6: The pixel word is sampled on the slot-6 step, and `pix_load_o` is high in that cycle. Changes to `pix_i` during the other six steps of the pixel have no effect on that pixel.
- R7: An enabled clock lane sends the pattern 1,1,0,0,0,1,1 across slots 6..0.
- R8: `lane_en_i[l]` set to 0 forces lane l to 0 on every channel.
- R9: With `dual_i`=0, logical channel 1 (data and clock lanes) is 0. With `dual_i`=1, both channels run. Logical channel c serializes `pix_i[c*28 +: 28]`.
- R10: With `swap_i`=1, physical channel 0 carries logical channel 1 and physical channel 1 carries logical channel 0.
- R11: When the block goes inactive, all lane outputs are 0 after the next clock. On reactivation, the sequence restarts at slot 6 with a fresh pixel load.
- R12: While active, outputs change only on clocks where `bit_en_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit-time enable |
| pix_i | input | NCH*28 | Pixel words, channel c at bits c*28+27:c*28 |
| sel_i | input | NLANE*35 | Per-lane, per-slot 5-bit source indices |
| lane_en_i | input | NLANE | Per-lane enable |
| depth_i | input | 2 | 01 = 18-bit, 10 = 24-bit, others rejected |
| dual_i | input | 1 | Dual-channel mode |
| swap_i | input | 1 | Exchange physical channels |
| intf_en_i | input | 1 | Interface enable, starts settling count |
| ser_en_i | input | 1 | Serialization enable |
| pix_load_o | output | 1 | Pixel word sampled this cycle |
| data_o | output | NCH*NLANE | Data lanes, physical channel p lane l at p*NLANE+l |
| clk_lane_o | output | NCH | Clock lane per physical channel |

## Verification
The bench sweeps the lane plans under irregular bit-enable gaps and random pixel words that change on every cycle. A design that sampled `pix_i` on every step instead of once per pixel would mismatch there, as would one that sent the slots in the wrong direction.

Sequences of illegal depth codes and early serialization enables expose a block that starts before the settling count ends or that ignores a rejected depth. Dual-channel and swap combinations, disabled lanes and the lane 3 gating in 18-bit mode catch wrong channel routing. A mid-pixel disable checks that a design which keeps its slot position across a restart, rather than beginning again at slot 6, is caught.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;
  localparam int SLOTS = 7;
  localparam int IDX_W = 5;
  localparam int POS_W = $clog2(SLOTS);
  localparam logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011;  // bit s = slot s

  typedef enum logic [1:0] {
    DEPTH_OFF = 2'b00,
    DEPTH_18  = 2'b01,
    DEPTH_24  = 2'b10,
    DEPTH_BAD = 2'b11
  } depth_e;
endpackage

// File: rtl/lvds_settle_ctrl.sv
module lvds_settle_ctrl #(
  parameter int SETTLE_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_ok_i,
  input  logic ser_en_i,
  output logic active_o
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!cfg_ok_i)       cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign active_o = cfg_ok_i && ser_en_i && (cnt_q == CNT_MAX);
endmodule

// File: rtl/lvds_slot_seq.sv
module lvds_slot_seq
  import lvds_ser_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             step_i,
  output logic [POS_W-1:0] slot_o,
  output logic             first_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(SLOTS - 1);

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pos_q <= '0;
    else if (!active_i) pos_q <= '0;
    else if (step_i)    pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
  end

  // pos 0 sends slot 6
  assign slot_o  = LAST - pos_q;
  assign first_o = (pos_q == '0);
endmodule

// File: rtl/lvds_lane_mux.sv
module lvds_lane_mux
  import lvds_ser_pkg::*;
#(
  parameter int WORD_W = 28
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   active_i,
  input  logic                   step_i,
  input  logic                   en_i,
  input  logic [POS_W-1:0]       slot_i,
  input  logic [WORD_W-1:0]      word_i,
  input  logic [SLOTS*IDX_W-1:0] sel_i,
  output logic                   bit_o
);
  logic [IDX_W-1:0] idx;
  logic             bit_nxt;

  assign idx     = sel_i[slot_i*IDX_W +: IDX_W];
  assign bit_nxt = (int'(idx) < WORD_W) ? word_i[idx] : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        bit_o <= 1'b0;
    else if (!active_i) bit_o <= 1'b0;
    else if (step_i)    bit_o <= en_i & bit_nxt;
  end
endmodule

// File: rtl/lvds_lane_serializer.sv
module lvds_lane_serializer
  import lvds_ser_pkg::*;
#(
  parameter int NCH        = 2,
  parameter int NLANE      = 4,
  parameter int WORD_W     = 28,
  parameter int LANES_18   = 3,
  parameter int SETTLE_CYC = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         bit_en_i,
  input  logic [NCH*WORD_W-1:0]        pix_i,
  input  logic [NLANE*SLOTS*IDX_W-1:0] sel_i,
  input  logic [NLANE-1:0]             lane_en_i,
  input  logic [1:0]                   depth_i,
  input  logic                         dual_i,
  input  logic                         swap_i,
  input  logic                         intf_en_i,
  input  logic                         ser_en_i,
  output logic                         pix_load_o,
  output logic [NCH*NLANE-1:0]         data_o,
  output logic [NCH-1:0]               clk_lane_o
);
  localparam int LANE_SEL_W = SLOTS * IDX_W;

  logic             depth_ok, depth_24, active, step, first, load;
  logic [POS_W-1:0] slot;
  logic [WORD_W-1:0] pix_q    [NCH];
  logic [WORD_W-1:0] word_cur [NCH];
  logic [NCH-1:0]    ch_on;

  assign depth_24 = (depth_e'(depth_i) == DEPTH_24);
  assign depth_ok = depth_24 || (depth_e'(depth_i) == DEPTH_18);
  assign step     = active && bit_en_i;
  assign load     = step && first;
  assign pix_load_o = load;

  lvds_settle_ctrl #(.SETTLE_CYC(SETTLE_CYC)) i_settle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_ok_i (intf_en_i && depth_ok),
    .ser_en_i (ser_en_i),
    .active_o (active)
  );

  lvds_slot_seq i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .step_i   (step),
    .slot_o   (slot),
    .first_o  (first)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   pix_q[c] <= '0;
      else if (load) pix_q[c] <= pix_i[c*WORD_W +: WORD_W];
    end
    // slot 6 uses the word being captured
    assign word_cur[c] = first ? pix_i[c*WORD_W +: WORD_W] : pix_q[c];
    assign ch_on[c]    = (c == 0) || dual_i;
  end

  for (genvar p = 0; p < NCH; p++) begin : g_phy
    logic [$clog2(NCH+1)-1:0] src;
    logic                     src_on;
    logic                     clk_q;

    assign src    = swap_i ? ($clog2(NCH+1))'(NCH-1-p) : ($clog2(NCH+1))'(p);
    assign src_on = ch_on[src];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      clk_q <= 1'b0;
      else if (!active) clk_q <= 1'b0;
      else if (step)    clk_q <= src_on & CLK_PATTERN[slot];
    end
    assign clk_lane_o[p] = clk_q;

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
      logic lane_on;
      if (l < LANES_18) begin : g_base
        assign lane_on = lane_en_i[l] && src_on;
      end else begin : g_wide
        assign lane_on = lane_en_i[l] && src_on && depth_24;
      end

      lvds_lane_mux #(.WORD_W(WORD_W)) i_mux (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .active_i (active),
        .step_i   (step),
        .en_i     (lane_on),
        .slot_i   (slot),
        .word_i   (word_cur[src]),
        .sel_i    (sel_i[l*LANE_SEL_W +: LANE_SEL_W]),
        .bit_o    (data_o[p*NLANE+l])
      );
    end
  end
endmodule

// File: rtl/lvds_lane_serializer_chk.sv
module lvds_lane_serializer_chk #(
  parameter int NCH   = 2,
  parameter int NLANE = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 bit_en_i,
  input logic [1:0]           depth_i,
  input logic                 dual_i,
  input logic                 swap_i,
  input logic                 intf_en_i,
  input logic                 active,
  input logic                 pix_load_o,
  input logic [NCH*NLANE-1:0] data_o,
  input logic [NCH-1:0]       clk_lane_o
);
  function automatic logic [NCH*NLANE-1:0] top_lane_mask();
    logic [NCH*NLANE-1:0] m = '0;
    for (int c = 0; c < NCH; c++) m[c*NLANE + NLANE-1] = 1'b1;
    return m;
  endfunction
  localparam logic [NCH*NLANE-1:0] TOP_MASK = top_lane_mask();

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> (data_o == '0) && (clk_lane_o == '0)) else $error("idle"); // R11
  AST_HOLD_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !bit_en_i) |=> $stable(data_o) && $stable(clk_lane_o)) else $error("hold"); // R12
  AST_LOAD_IN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_load_o |-> (active && bit_en_i)) else $error("load"); // R6
  AST_START_AFTER_INTF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active) |-> $past(intf_en_i)) else $error("settle"); // R2
  AST_BAD_DEPTH_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(depth_i == 2'b01 || depth_i == 2'b10) |-> !active) else $error("depth"); // R3
  AST_TOP_LANE_18: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_i == 2'b01) |=> ((data_o & TOP_MASK) == '0)) else $error("lane3"); // R3
  AST_SINGLE_CH_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dual_i && !swap_i) |=> (data_o[(NCH-1)*NLANE +: NLANE] == '0) && !clk_lane_o[NCH-1])
    else $error("single"); // R9
  AST_CLK_FIRST_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_load_o && !swap_i) |=> clk_lane_o[0]) else $error("clk"); // R7
endmodule

bind lvds_lane_serializer lvds_lane_serializer_chk #(.NCH(NCH), .NLANE(NLANE)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_en_i   (bit_en_i),
  .depth_i    (depth_i),
  .dual_i     (dual_i),
  .swap_i     (swap_i),
  .intf_en_i  (intf_en_i),
  .active     (active),
  .pix_load_o (pix_load_o),
  .data_o     (data_o),
  .clk_lane_o (clk_lane_o)
);

// File: tb/test_lvds_lane_serializer.sv
module test_lvds_lane_serializer;
  localparam int NCH = 2, NLANE = 4, WORD_W = 28, SETTLE = 8, SLOTS = 7, IDX_W = 5;
  localparam logic [6:0] PAT = 7'b1100011;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic                         bit_en = 0, intf_en = 0, ser_en = 0, dual = 0, swap = 0;
  logic [NCH*WORD_W-1:0]        pix = '0;
  logic [NLANE*SLOTS*IDX_W-1:0] sel = '0;
  logic [NLANE-1:0]             lane_en = '0;
  logic [1:0]                   depth = 2'b00;
  logic                         pix_load;
  logic [NCH*NLANE-1:0]         data;
  logic [NCH-1:0]               clk_lane;

  int n_run = 0, n_fail = 0;
  int scnt = 0, epos = 0;
  logic [WORD_W-1:0]    cap [NCH];
  logic [NCH*NLANE-1:0] edata = '0;
  logic [NCH-1:0]       eclk = '0;

  lvds_lane_serializer #(.NCH(NCH), .NLANE(NLANE), .WORD_W(WORD_W), .SETTLE_CYC(SETTLE))
  i_lvds_lane_serializer (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .pix_i(pix), .sel_i(sel),
    .lane_en_i(lane_en), .depth_i(depth), .dual_i(dual), .swap_i(swap),
    .intf_en_i(intf_en), .ser_en_i(ser_en), .pix_load_o(pix_load),
    .data_o(data), .clk_lane_o(clk_lane)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic put(int l, int s, int v);
    sel[(l*SLOTS+s)*IDX_W +: IDX_W] = IDX_W'(v);
  endtask

  task automatic tick(bit be, string tag);
    logic [63:0] r;
    bit ok, act, eload;
    @(negedge clk);
    bit_en = be;
    r = {$urandom(), $urandom()};
    pix = r[NCH*WORD_W-1:0];
    #1;
    ok    = intf_en && (depth == 2'b01 || depth == 2'b10);
    act   = ok && ser_en && (scnt == SETTLE);
    eload = act && be && (epos == 0);
    check({tag, " load"}, 32'(pix_load), 32'(eload));
    if (!ok) scnt = 0; else if (scnt < SETTLE) scnt++;
    if (!act) begin
      edata = '0; eclk = '0; epos = 0;
    end else if (be) begin
      int slot;
      if (epos == 0) for (int c = 0; c < NCH; c++) cap[c] = pix[c*WORD_W +: WORD_W];
      slot = SLOTS - 1 - epos;
      for (int p = 0; p < NCH; p++) begin
        int src;
        bit chen;
        src  = swap ? NCH - 1 - p : p;
        chen = (src == 0) || dual;
        eclk[p] = chen && PAT[slot];
        for (int l = 0; l < NLANE; l++) begin
          int idx;
          bit b;
          idx = int'(sel[(l*SLOTS+slot)*IDX_W +: IDX_W]);
          b   = (idx < WORD_W) ? cap[src][idx] : 1'b0;
          edata[p*NLANE+l] = lane_en[l] && (l < 3 || depth == 2'b10) && chen && b;
        end
      end
      epos = (epos + 1) % SLOTS;
    end
    @(posedge clk);
    #1;
    check(tag, 32'({clk_lane, data}), 32'({eclk, edata}));
  endtask

  task automatic run(int n, int dens, string tag);
    for (int i = 0; i < n; i++) tick(($urandom() % 8) < dens, tag);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 32'({pix_load, clk_lane, data}), 32'h0);
    rst_n = 1'b1;
    repeat (3) tick(1, "R1");

    // 24-bit plan
    for (int s = 0; s < SLOTS; s++) begin
      put(0, s, (s == 0) ? 8 : 6 - s);
      put(1, s, 9 + s);
      put(2, s, 16 + s);
    end
    put(3, 0, 27); put(3, 1, 23); put(3, 2, 22); put(3, 3, 15);
    put(3, 4, 14); put(3, 5, 7);  put(3, 6, 6);
    depth = 2'b10; lane_en = 4'hF; intf_en = 1; ser_en = 1;
    repeat (SETTLE) tick(1, "R2");
    run(140, 5, "R4");
    run(70, 8, "R7");
    run(70, 2, "R6");
    run(60, 1, "R12");

    // 18-bit plan
    for (int s = 0; s < SLOTS; s++) begin
      put(0, s, (s == 0) ? 10 : 8 - s);
      put(1, s, 11 + s);
      put(2, s, 20 + s);
    end
    depth = 2'b01;
    run(100, 6, "R3");

    // indices over the word
    depth = 2'b10;
    for (int l = 0; l < NLANE; l++)
      for (int s = 0; s < SLOTS; s++) put(l, s, (l*11 + s*5) % 32);
    run(100, 6, "R5");

    lane_en = 4'b0101;
    run(70, 6, "R8");
    lane_en = 4'hF; dual = 1;
    run(100, 6, "R9");
    swap = 1;
    run(70, 6, "R10");
    dual = 0;
    run(70, 6, "R10");
    swap = 0;

    depth = 2'b00; run(20, 6, "R3");
    depth = 2'b11; run(20, 6, "R3");
    depth = 2'b10; run(SETTLE + 10, 8, "R2");
    intf_en = 0; run(4, 8, "R2");
    intf_en = 1; ser_en = 0; run(SETTLE + 4, 8, "R2");
    ser_en = 1; run(24, 8, "R2");

    repeat (3) tick(1, "R11");
    ser_en = 0;
    repeat (3) tick(1, "R11");
    ser_en = 1;
    run(50, 6, "R11");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule